// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter clocked by one of eight taps of a free-running prescaler. It is controlled through one 8-bit control/status register. When the counter steps from 0xFF to 0x00 the block latches an overflow flag. In watchdog mode the overflow also emits a fixed-length reset request pulse. In interval mode the flag drives a level interrupt request until software clears it.

Software reaches the two registers over a small bus with an address bit, a 16-bit write word, write and read strobes, and combinational read data. Every write must carry a key in its upper byte, otherwise the write is dropped. The flag can only be cleared by software, and only in a set order: first a read of the control register that sees the flag at 1, then a write of 0 to it. A standby input clears the flag, mode and enable bits. It leaves the clock selection as it was.

Top module: `wdt_top`

## Requirements
- R1: After reset the control register reads 0x18, the counter reads 0x00, and rst_req_o and irq_o are low.
- R2: Control register layout (address 0): bit 7 overflow flag, bit 6 mode (1 = watchdog, 0 = interval), bit 5 enable, bits 2:0 clock select. Bits 4:3 always read 1 and ignore writes. The counter is read at address 1. rdata_o shows the register picked by addr_i.
- R3: A control write takes effect only when wdata_i[15:8] is 0xA5. A counter write takes effect only when wdata_i[15:8] is 0x5A. Any other write leaves both registers unchanged.
- R4: A valid control write loads mode from bit 6, enable from bit 5 and clock select from bits 2:0.
- R5: While enable is 0 the counter is held at 0x00, ignoring ticks and counter writes. Clearing enable zeroes the counter.
- R6: Clock select 0 to 7 picks the system clock divided by 2, 32, 64, 128, 256, 512, 2048 and 4096, taken from a free-running prescaler. The counter increments once per selected tick.
- R7: The overflow flag sets when an enabled counter steps from 0xFF to 0x00. A valid counter write in the same cycle as a tick wins over the increment.
- R8: Software cannot set the flag. It clears only on a valid control write with bit 7 = 0 that follows a control read which returned the flag as 1. A write of 1, or a write of 0 with no such earlier read, leaves the flag set.
- R9: In interval mode irq_o is high exactly while the flag is set.
- R10: In watchdog mode an overflow drives rst_req_o high for exactly 8 clock cycles, and irq_o stays low.
- R11: While standby_i is high, bits 7:5 are cleared, clock select keeps its value, and control writes are ignored. The counter therefore reads 0x00.
- R12: When an overflow and a valid clear land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby level; partial register reinitialisation |
| addr_i | input | 1 | Register select: 0 control, 1 counter |
| wdata_i | input | 16 | Write word: key in [15:8], data in [7:0] |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (arms the flag clear) |
| rdata_o | output | 8 | Combinational read data of the addressed register |
| rst_req_o | output | 1 | Reset request pulse (watchdog mode) |
| irq_o | output | 1 | Interrupt request (interval mode) |

## Verification
The counter overflow and a software flag clear can fall in the same clock edge. The bench provokes this with the divide-by-2 tap. It first finds the tick phase by writing the counter to zero and watching for its first increment. It then times a keyed counter write of 0xFF so that the wrap edge is the very edge on which an armed, keyed write of 0 to the flag lands. The flag must read 1 and the counter 0x00 afterwards, and a later clear must still work.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam int CKS_W  = 3;
  localparam int NUM_CKS = 1 << CKS_W;
  localparam int RST_LEN = 8;
  localparam logic [7:0] KEY_CTRL = 8'hA5;
  localparam logic [7:0] KEY_CNT  = 8'h5A;
  localparam logic       ADDR_CTRL = 1'b0;
  localparam logic       ADDR_CNT  = 1'b1;

  typedef struct packed {
    logic             ovf;
    logic             wd_mode;
    logic             tme;
    logic [1:0]       rsv;
    logic [CKS_W-1:0] cks;
  } ctrl_t;

  // log2 of the prescaler division for each clock select code
  function automatic int div_log2(input int sel);
    case (sel)
      0: return 1;
      1: return 5;
      2: return 6;
      3: return 7;
      4: return 8;
      5: return 9;
      6: return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CKS_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = div_log2(NUM_CKS - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_CKS-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CKS; g++) begin : g_tap
    localparam int SH = div_log2(g);
    assign taps[g] = &pre_q[SH-1:0];
  end

  assign tick_o = taps[sel_i];

  assert_div2_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taps[0] |=> !taps[0]);
  assert_div2_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taps[0] |=> taps[0]);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tme_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_evt_o
);
  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!tme_i) cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_evt_o = tme_i && tick_i && !wr_i && (cnt_q == '1);
  assign cnt_o     = cnt_q;

  assert_cnt_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tme_i |=> cnt_q == '0);
  assert_cnt_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tme_i && tick_i && !wr_i && cnt_q == '1) |=> cnt_q == '0);
  assert_cnt_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tme_i && wr_i) |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             wr_i,
  input  logic             wr_ovf_i,
  input  logic             wr_mode_i,
  input  logic             wr_tme_i,
  input  logic [CKS_W-1:0] wr_cks_i,
  input  logic             rd_i,
  input  logic             ovf_evt_i,
  output ctrl_t            ctrl_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic             ovf_q, wd_mode_q, tme_q, armed_q;
  logic [CKS_W-1:0] cks_q;
  logic [PW-1:0]    pulse_q;
  logic             clr_ok, ovf_d;

  // clear accepted only after a read that observed the flag set
  assign clr_ok = wr_i && !wr_ovf_i && armed_q && ovf_q;

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_evt_i)   ovf_d = 1'b1;
    else if (clr_ok) ovf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      wd_mode_q <= 1'b0;
      tme_q     <= 1'b0;
      armed_q   <= 1'b0;
      cks_q     <= '0;
    end else if (standby_i) begin
      ovf_q     <= 1'b0;
      wd_mode_q <= 1'b0;
      tme_q     <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      ovf_q   <= ovf_d;
      armed_q <= ovf_d && (armed_q || (rd_i && ovf_q));
      if (wr_i) begin
        wd_mode_q <= wr_mode_i;
        tme_q     <= wr_tme_i;
        cks_q     <= wr_cks_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pulse_q <= '0;
    else if (ovf_evt_i && wd_mode_q)  pulse_q <= PW'(RST_LEN);
    else if (pulse_q != '0)           pulse_q <= pulse_q - 1'b1;
  end

  assign rst_req_o = (pulse_q != '0);
  assign irq_o     = ovf_q && !wd_mode_q;

  always_comb begin
    ctrl_o.ovf     = ovf_q;
    ctrl_o.wd_mode = wd_mode_q;
    ctrl_o.tme     = tme_q;
    ctrl_o.rsv     = 2'b11;
    ctrl_o.cks     = cks_q;
  end

  assert_ovf_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(ovf_evt_i));
  assert_ovf_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> ($past(standby_i) || $past(armed_q)));
  assert_ovf_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_i && !standby_i) |=> ovf_q);
  assert_standby_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!ovf_q && !tme_q && !wd_mode_q && $stable(cks_q)));
  assert_rst_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(ovf_evt_i && wd_mode_q));
  assert_irq_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_mode_q |-> !irq_o);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        standby_i,
  input  logic        addr_i,
  input  logic [15:0] wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [7:0]  rdata_o,
  output logic        rst_req_o,
  output logic        irq_o
);
  ctrl_t             ctrl_s;
  logic              tick_s, ovf_evt_s;
  logic              wr_ctrl_s, wr_cnt_s, rd_ctrl_s;
  logic [DATA_W-1:0] cnt_s;

  assign wr_ctrl_s = we_i && (addr_i == ADDR_CTRL) && (wdata_i[15:8] == KEY_CTRL);
  assign wr_cnt_s  = we_i && (addr_i == ADDR_CNT)  && (wdata_i[15:8] == KEY_CNT);
  assign rd_ctrl_s = re_i && (addr_i == ADDR_CTRL);

  wdt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ctrl_s.cks),
    .tick_o (tick_s)
  );

  wdt_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_s),
    .tme_i     (ctrl_s.tme),
    .wr_i      (wr_cnt_s),
    .wdata_i   (wdata_i[7:0]),
    .cnt_o     (cnt_s),
    .ovf_evt_o (ovf_evt_s)
  );

  wdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .wr_i      (wr_ctrl_s),
    .wr_ovf_i  (wdata_i[7]),
    .wr_mode_i (wdata_i[6]),
    .wr_tme_i  (wdata_i[5]),
    .wr_cks_i  (wdata_i[2:0]),
    .rd_i      (rd_ctrl_s),
    .ovf_evt_i (ovf_evt_s),
    .ctrl_o    (ctrl_s),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o)
  );

  assign rdata_o = (addr_i == ADDR_CNT) ? cnt_s : ctrl_s;

  assert_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL && wdata_i[15:8] != KEY_CTRL && !standby_i)
      |=> $stable({ctrl_s.wd_mode, ctrl_s.tme, ctrl_s.cks}));
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        standby_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        rst_req_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  wdt_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o),
    .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp<=190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] key, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = {key, d}; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 v = rdata_o;
    @(posedge clk_i);
    #1 re_i = 1'b0;
  endtask

  function automatic int bdiv(input int s);
    int t[8] = '{2, 32, 64, 128, 256, 512, 2048, 4096};
    return t[s];
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R1 ctrl reset", v, 8'h18);
    rd(1'b1, v); chk("R1 cnt reset", v, 0);
    chk("R1 rst_req reset", rst_req_o, 0);
    chk("R1 irq reset", irq_o, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(1'b0, 8'h00, 8'h27); rd(1'b0, v); chk("R3 ctrl no key", v, 8'h18);
    wr(1'b0, 8'h5A, 8'h27); rd(1'b0, v); chk("R3 ctrl wrong key", v, 8'h18);
    wr(1'b0, 8'hA5, 8'h47); rd(1'b0, v); chk("R4 ctrl load", v, 8'h5F);
    wr(1'b0, 8'hA5, 8'h00); rd(1'b0, v); chk("R2 reserved read 1", v, 8'h18);
    rd(1'b1, v); chk("R2 addr select cnt", v, 0);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr(1'b0, 8'hA5, 8'h00);
    wr(1'b1, 8'h5A, 8'h40);
    repeat (20) @(negedge clk_i);
    rd(1'b1, v); chk("R5 disabled hold 0", v, 0);
    wr(1'b0, 8'hA5, 8'h27);
    wr(1'b1, 8'hA5, 8'h80); rd(1'b1, v);
    chk("R3 cnt wrong key", int'(v < 8'h02), 1);
    wr(1'b1, 8'h5A, 8'h80); rd(1'b1, v);
    chk("R3 cnt keyed", int'(v == 8'h80 || v == 8'h81), 1);
    wr(1'b0, 8'hA5, 8'h07); rd(1'b1, v); chk("R5 disable clears", v, 0);
  endtask

  task automatic t_divide(input int s, input int n);
    logic [7:0] c0, c1;
    wr(1'b0, 8'hA5, 8'(32'h20 | s));
    rd(1'b1, c0);
    repeat (n * bdiv(s) - 1) @(posedge clk_i);
    rd(1'b1, c1);
    chk($sformatf("R6 divide sel %0d", s), int'(8'(c1 - c0)), n);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    wr(1'b0, 8'hA5, 8'h20);
    wr(1'b1, 8'h5A, 8'hF0);
    repeat (20) @(negedge clk_i);
    chk("R7 no early flag", irq_o, 0);
    repeat (20) @(negedge clk_i);
    chk("R9 irq on overflow", irq_o, 1);
    wr(1'b0, 8'hA5, 8'h20); chk("R8 clear without read", irq_o, 1);
    wr(1'b0, 8'hA5, 8'hA0); chk("R8 write one ignored", irq_o, 1);
    rd(1'b0, v); chk("R7 flag read", v, 8'hB8);
    wr(1'b0, 8'hA5, 8'h20); chk("R9 irq drops after clear", irq_o, 0);
    rd(1'b0, v); chk("R8 flag cleared", v, 8'h38);
    wr(1'b0, 8'hA5, 8'hA0); rd(1'b0, v); chk("R8 cannot set", v, 8'h38);
  endtask

  task automatic t_race();
    logic [7:0] v;
    int n = 0;
    while (irq_o !== 1'b1 && n < 700) begin @(negedge clk_i); n++; end
    chk("R7 second overflow", irq_o, 1);
    rd(1'b0, v);
    wr(1'b1, 8'h5A, 8'h00);
    addr_i = 1'b1;
    n = 0;
    do begin @(negedge clk_i); #1; n++; end while (rdata_o == 8'h00 && n < 10);
    we_i = 1'b1; addr_i = 1'b1; wdata_i = {8'h5A, 8'hFF};
    @(negedge clk_i);
    addr_i = 1'b0; wdata_i = {8'hA5, 8'h20};
    @(negedge clk_i);
    we_i = 1'b0; #1;
    chk("R12 flag kept", rdata_o[7], 1);
    addr_i = 1'b1; #1;
    chk("R12 counter wrapped", rdata_o, 0);
    wr(1'b0, 8'hA5, 8'h20); rd(1'b0, v);
    chk("R12 later clear", v[7], 0);
  endtask

  task automatic t_watchdog();
    logic [7:0] v;
    int hi = 0, ir = 0;
    wr(1'b0, 8'hA5, 8'h60);
    wr(1'b1, 8'h5A, 8'hF8);
    repeat (60) begin
      @(negedge clk_i);
      hi += int'(rst_req_o);
      ir += int'(irq_o);
    end
    chk("R10 pulse length", hi, 8);
    chk("R10 no irq", ir, 0);
    rd(1'b0, v); chk("R10 flag set", v, 8'hF8);
  endtask

  task automatic t_standby();
    logic [7:0] v;
    wr(1'b0, 8'hA5, 8'hE5);
    @(negedge clk_i); standby_i = 1'b1;
    wr(1'b0, 8'hA5, 8'h62);
    @(negedge clk_i); standby_i = 1'b0;
    rd(1'b0, v); chk("R11 standby ctrl", v, 8'h1D);
    rd(1'b1, v); chk("R11 standby cnt", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_enable();
    t_divide(0, 40);
    t_divide(1, 10);
    t_divide(3, 6);
    t_divide(7, 3);
    t_flag();
    t_race();
    t_watchdog();
    t_standby();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule